// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block sits between a large bank of GPIO input lines and a parent interrupt controller that has only a few interrupt inputs. Each of its eight output channels picks one GPIO through an 8-bit selector. The selected line passes through a two-flop synchroniser and an optional glitch filter. It is then turned into an interrupt, either as a level with programmable polarity or as a one-clock pulse on a single programmed edge. All configuration sits in four 32-bit word registers on a simple read/write bus with byte addresses.

An edge-mode channel reacts to only one direction of change. Software that needs both edges of a pin points two channels at the same GPIO and gives them opposite polarities. A selector holding all ones disconnects its channel. A write that reconfigures a channel flushes that channel's detection history, so the change of source or mode cannot produce an interrupt by itself.

Top module: `gpio_irq_mux`

## Requirements
- R1: Channels 0 to 3 take their selectors from the word at byte offset 0x04 and channels 4 to 7 from the word at 0x08. Channel n uses bits 8*(n mod 4)+7 down to 8*(n mod 4), and the value is the index of the GPIO line it watches.
- R2: A selector value of 0xFF disconnects the channel, and its interrupt output then stays low whatever the GPIO lines do.
- R3: In the word at offset 0x00, bit n set puts channel n in edge mode and bit n clear puts it in level mode. Bit 16+n set selects active-low level or falling edge, and bit 16+n clear selects active-high level or rising edge.
- R4: In level mode with filtering off, the output equals the selected GPIO, inverted when the polarity bit is set. A change on the pin shows at the output after exactly three rising clock edges.
- R5: In edge mode the output is high for exactly one clock on each programmed edge of the selected GPIO, and it stays low on the opposite edge.
- R6: Two channels in edge mode that select the same GPIO with opposite polarities together report both edges of that pin, each channel reporting its own edge.
- R7: A write to the mode word reconfigures all channels, and a write to a selector word reconfigures the four channels of that word. A reconfigured channel holds its output low for the cycle after the write, then restarts detection from the current level of its new source, so the reconfiguration itself produces no edge pulse.
- R8: In the filter word at offset 0x0C, bits 3n+2 down to 3n give channel n a length k. When k is nonzero, a change is passed on only after the synchronised input has held its new value for 4*k clocks, so a shorter glitch is dropped. When k is 0 there is no filtering.
- R9: After reset the mode word and the filter word read 0, both selector words read 0xFFFFFFFF, and every interrupt output is low.
- R10: Each mapped word reads back exactly the last value written to it. Any address that is not 0x00, 0x04, 0x08 or 0x0C (including one whose two low bits are nonzero) reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register of the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| gpio_in | input | GPIO_N | Asynchronous GPIO input lines |
| irq_out | output | 8 | Interrupt lines toward the parent controller, one per channel |

## Verification
The bound checker watches four things on every cycle. A channel whose selector is 0xFF never raises its output. An edge-mode pulse never lasts beyond one clock. A write to an unmapped address leaves all four words unchanged. A mapped word returns the written data on the next cycle and unmapped addresses read 0. The bench scenarios cover what needs a stimulus history: the three-edge level latency, the single-edge selectivity, two channels sharing one pin, the filter's rejection of short glitches and its exact acceptance delay, and the absence of a pulse when a channel is moved to a new source that sits at a different level.

// File: rtl/gim_pkg.sv
package gim_pkg;
   // Fixed by the register map: eight channels with byte-wide selectors
   localparam int unsigned NCH      = 8;
   localparam int unsigned DW       = 32;
   localparam int unsigned SEL_W    = 8;
   localparam int unsigned KLEN_W   = 3;
   localparam int unsigned POL_BASE = 16;

   // word index (byte address / 4) of each register
   typedef enum logic [1:0] {
      W_MODE  = 2'd0,
      W_SELLO = 2'd1,
      W_SELHI = 2'd2,
      W_FILT  = 2'd3
   } word_e;

   localparam logic [SEL_W-1:0] SEL_OFF = '1;
endpackage

// File: rtl/gim_regs.sv
module gim_regs
   import gim_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [DW-1:0]     mode_q,
   output logic [DW-1:0]     sel_lo_q,
   output logic [DW-1:0]     sel_hi_q,
   output logic [DW-1:0]     filt_q,
   output logic [NCH-1:0]    reconf
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] widx;
   logic              hit;
   word_e             wsel;

   assign widx = bus_addr[ADDR_W-1:2];
   assign hit  = (bus_addr[1:0] == 2'b00) && (widx < WIDX_W'(4));
   assign wsel = word_e'(widx[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         sel_lo_q <= '1;
         sel_hi_q <= '1;
         filt_q   <= '0;
      end else if (bus_wr && hit) begin
         case (wsel)
            W_MODE:  mode_q   <= bus_wdata;
            W_SELLO: sel_lo_q <= bus_wdata;
            W_SELHI: sel_hi_q <= bus_wdata;
            default: filt_q   <= bus_wdata;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (wsel)
            W_MODE:  bus_rdata = mode_q;
            W_SELLO: bus_rdata = sel_lo_q;
            W_SELHI: bus_rdata = sel_hi_q;
            default: bus_rdata = filt_q;
         endcase
      end
   end

   // channels whose history must be flushed by this write
   always_comb begin
      reconf = '0;
      if (bus_wr && hit) begin
         case (wsel)
            W_MODE:  reconf = '1;
            W_SELLO: reconf = NCH'(8'h0F);
            W_SELHI: reconf = NCH'(8'hF0);
            default: reconf = '0;
         endcase
      end
   end
endmodule

// File: rtl/gim_chan.sv
module gim_chan
   import gim_pkg::*;
#(
   parameter int unsigned GPIO_N    = 256,
   parameter bit          FILTER_EN = 1'b1,
   parameter int unsigned FLT_UNIT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GPIO_N-1:0] gpio_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic              edge_md,
   input  logic              pol_low,
   input  logic [KLEN_W-1:0] klen,
   input  logic              reconf,
   output logic              irq
);
   localparam int unsigned IDX_W  = (GPIO_N > 1) ? $clog2(GPIO_N) : 1;
   localparam bit          FULL   = (GPIO_N >= (1 << SEL_W));
   localparam int unsigned KMAX   = (1 << KLEN_W) - 1;
   localparam int unsigned CNT_W  = $clog2(KMAX * FLT_UNIT + 1);
   localparam logic [CNT_W-1:0] UNIT_C = CNT_W'(FLT_UNIT);

   logic             en, in_rng, raw;
   logic             s1_q, s2_q, flt_q, prev_q, flush_q;
   logic             flt_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign en     = (sel != SEL_OFF);
   assign in_rng = FULL ? 1'b1 : (32'(sel) < GPIO_N);
   assign raw    = en && in_rng && gpio_in[sel[IDX_W-1:0]];

   generate
      if (FILTER_EN) begin : g_filt
         logic [CNT_W-1:0] lim;
         assign lim = CNT_W'(klen) * UNIT_C;
         always_comb begin
            flt_d = flt_q;
            cnt_d = '0;
            if (klen == '0) begin
               flt_d = s2_q;
            end else if (s2_q != flt_q) begin
               if (cnt_q >= lim - CNT_W'(1)) flt_d = s2_q;
               else                          cnt_d = cnt_q + CNT_W'(1);
            end
         end
      end else begin : g_nofilt
         assign flt_d = s2_q;
         assign cnt_d = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q    <= 1'b0;
         s2_q    <= 1'b0;
         flt_q   <= 1'b0;
         prev_q  <= 1'b0;
         cnt_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= reconf;
         if (flush_q) begin
            // restart every stage from the new source's present level
            s1_q   <= raw;
            s2_q   <= raw;
            flt_q  <= raw;
            prev_q <= raw;
            cnt_q  <= '0;
         end else begin
            s1_q   <= raw;
            s2_q   <= s1_q;
            flt_q  <= flt_d;
            prev_q <= flt_q;
            cnt_q  <= cnt_d;
         end
      end
   end

   always_comb begin
      if (!en || flush_q)  irq = 1'b0;
      else if (edge_md)    irq = pol_low ? (prev_q & ~flt_q) : (~prev_q & flt_q);
      else                 irq = flt_q ^ pol_low;
   end
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
   import gim_pkg::*;
#(
   parameter int unsigned GPIO_N    = 256,
   parameter int unsigned ADDR_W    = 5,
   parameter bit          FILTER_EN = 1'b1,
   parameter int unsigned FLT_UNIT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [GPIO_N-1:0] gpio_in,
   output logic [7:0]        irq_out
);
   generate
      if (ADDR_W < 4)             $error("ADDR_W must cover offsets up to 0x0C");
      if (GPIO_N < 1)             $error("GPIO_N must be at least 1");
      if (GPIO_N > (1 << SEL_W))  $error("GPIO_N exceeds selector range");
      if (FLT_UNIT < 1)           $error("FLT_UNIT must be nonzero");
   endgenerate

   logic [DW-1:0]  mode_q, sel_lo_q, sel_hi_q, filt_q;
   logic [NCH-1:0] reconf;

   gim_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mode_q    (mode_q),
      .sel_lo_q  (sel_lo_q),
      .sel_hi_q  (sel_hi_q),
      .filt_q    (filt_q),
      .reconf    (reconf)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam int unsigned BYTE_LO = SEL_W * (n % 4);
      logic [SEL_W-1:0] sel;
      if (n < 4) begin : g_lo
         assign sel = sel_lo_q[BYTE_LO +: SEL_W];
      end else begin : g_hi
         assign sel = sel_hi_q[BYTE_LO +: SEL_W];
      end

      gim_chan #(
         .GPIO_N    (GPIO_N),
         .FILTER_EN (FILTER_EN),
         .FLT_UNIT  (FLT_UNIT)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .gpio_in (gpio_in),
         .sel     (sel),
         .edge_md (mode_q[n]),
         .pol_low (mode_q[POL_BASE + n]),
         .klen    (filt_q[KLEN_W*n +: KLEN_W]),
         .reconf  (reconf[n]),
         .irq     (irq_out[n])
      );
   end
endmodule

// File: rtl/gim_chk.sv
module gim_chk
   import gim_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [7:0]        irq_out,
   input logic [31:0]       mode_q,
   input logic [31:0]       sel_lo_q,
   input logic [31:0]       sel_hi_q,
   input logic [31:0]       filt_q
);
   logic mapped;
   assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] <= (ADDR_W-2)'(3));

   for (genvar n = 0; n < 8; n++) begin : g_c
      logic [7:0] csel;
      if (n < 4) begin : g_lo
         assign csel = sel_lo_q[8*(n%4) +: 8];
      end else begin : g_hi
         assign csel = sel_hi_q[8*(n%4) +: 8];
      end

      // R2
      sel_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (csel == SEL_OFF) |-> !irq_out[n]);

      // R5
      edge_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[n] && irq_out[n]) |=> (!irq_out[n] || !mode_q[n]));
   end

   // R10
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !mapped) |=> ($stable(mode_q) && $stable(sel_lo_q)
                               && $stable(sel_hi_q) && $stable(filt_q)));

   // R10
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && mapped) |=> (!$stable(bus_addr) || bus_rdata == $past(bus_wdata)));

   // R10
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == 32'h0));
endmodule

bind gpio_irq_mux gim_chk #(.ADDR_W(ADDR_W)) u_gim_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .mode_q    (mode_q),
   .sel_lo_q  (sel_lo_q),
   .sel_hi_q  (sel_hi_q),
   .filt_q    (filt_q)
);

// File: tb/tb_gpio_irq_mux.sv
module tb_gpio_irq_mux;
   localparam int GPIO_N = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [GPIO_N-1:0] gpio_in = '0;
   logic [7:0]        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int pc [8];
   int pw [8];

   always #5 clk = ~clk;

   gpio_irq_mux dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .gpio_in   (gpio_in),
      .irq_out   (irq_out)
   );

   // level vectors: [13:11] channel, [10] active-low, [9:2] gpio index,
   // [1] pin value, [0] expected interrupt level
   localparam logic [13:0] LVEC [7] = '{
      {3'd0, 1'b0, 8'd5,   1'b1, 1'b1},
      {3'd0, 1'b0, 8'd5,   1'b0, 1'b0},
      {3'd3, 1'b1, 8'd200, 1'b0, 1'b1},
      {3'd3, 1'b1, 8'd200, 1'b1, 1'b0},
      {3'd4, 1'b0, 8'd254, 1'b1, 1'b1},
      {3'd7, 1'b1, 8'd0,   1'b1, 1'b0},
      {3'd6, 1'b0, 8'd1,   1'b1, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // counts high cycles and longest high run per channel, starting now
   task automatic watch(input int cyc);
      int run [8];
      for (int c = 0; c < 8; c++) begin pc[c] = 0; pw[c] = 0; run[c] = 0; end
      for (int t = 0; t < cyc; t++) begin
         for (int c = 0; c < 8; c++) begin
            if (irq_out[c]) begin
               if (run[c] == 0) pc[c]++;
               run[c]++;
               if (run[c] > pw[c]) pw[c] = run[c];
            end else run[c] = 0;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] lo, hi;
      gpio_in = '1;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R9 reset state
      rd(5'h00, d); check("R9 mode reset", d, 32'h0);
      rd(5'h04, d); check("R9 sel lo reset", d, 32'hFFFF_FFFF);
      rd(5'h08, d); check("R9 sel hi reset", d, 32'hFFFF_FFFF);
      rd(5'h0C, d); check("R9 filter reset", d, 32'h0);
      idle(4);
      check("R9 irq low after reset", {24'h0, irq_out}, 32'h0);

      // R10 unmapped reads and writes
      rd(5'h10, d); check("R10 read 0x10", d, 32'h0);
      rd(5'h02, d); check("R10 read 0x02", d, 32'h0);
      wr(5'h10, 32'h1234_5678);
      wr(5'h05, 32'h0000_0000);
      wr(5'h1C, 32'h0000_0000);
      rd(5'h00, d); check("R10 mode untouched", d, 32'h0);
      rd(5'h04, d); check("R10 sel lo untouched", d, 32'hFFFF_FFFF);
      rd(5'h08, d); check("R10 sel hi untouched", d, 32'hFFFF_FFFF);
      rd(5'h0C, d); check("R10 filter untouched", d, 32'h0);
      check("R10 irq still low", {24'h0, irq_out}, 32'h0);

      // R10 readback
      wr(5'h0C, 32'hDEAD_BEEF); rd(5'h0C, d); check("R10 filter readback", d, 32'hDEAD_BEEF);
      wr(5'h00, 32'hA5A5_5A5A); rd(5'h00, d); check("R10 mode readback", d, 32'hA5A5_5A5A);
      wr(5'h00, 32'h0);
      wr(5'h0C, 32'h0);
      gpio_in = '0;

      // R1 R3 R4 level vector table
      for (int v = 0; v < 7; v++) begin
         logic [2:0] ch;
         logic       pl, val, exp;
         logic [7:0] idx;
         {ch, pl, idx, val, exp} = LVEC[v];
         lo = '1; hi = '1;
         if (ch < 4) lo[8*(ch%4) +: 8] = idx;
         else        hi[8*(ch%4) +: 8] = idx;
         wr(5'h00, 32'(pl) << (16 + ch));
         wr(5'h04, lo);
         wr(5'h08, hi);
         gpio_in      = '0;
         gpio_in[idx] = val;
         idle(8);
         check($sformatf("R1 R3 R4 vector %0d", v), {24'h0, irq_out}, 32'(exp) << ch);
      end

      // R2 disconnected channel ignores an active-low idle pin
      wr(5'h00, 32'h0001_0000);
      wr(5'h04, 32'hFFFF_FFFF);
      wr(5'h08, 32'hFFFF_FFFF);
      gpio_in = '0;
      idle(8);
      check("R2 selector 0xFF stays low", {24'h0, irq_out}, 32'h0);

      // R4 exact three-edge latency
      wr(5'h00, 32'h0);
      wr(5'h04, 32'hFFFF_FF09);
      idle(8);
      gpio_in[9] = 1'b1;
      @(negedge clk); check("R4 edge1 still low", 32'(irq_out[0]), 32'h0);
      @(negedge clk); check("R4 edge2 still low", 32'(irq_out[0]), 32'h0);
      @(negedge clk); check("R4 edge3 high", 32'(irq_out[0]), 32'h1);

      // R5 R6 ch1 rising, ch2 falling, both on gpio 10
      gpio_in = '0;
      wr(5'h00, 32'h0004_0006);
      wr(5'h04, 32'hFF0A_0AFF);
      idle(8);
      gpio_in[10] = 1'b1;
      watch(12);
      check("R5 rising pulse count ch1", pc[1], 1);
      check("R5 rising pulse width ch1", pw[1], 1);
      check("R5 R6 falling ch2 silent on rise", pc[2], 0);
      gpio_in[10] = 1'b0;
      watch(12);
      check("R6 falling pulse count ch2", pc[2], 1);
      check("R6 falling pulse width ch2", pw[2], 1);
      check("R5 rising ch1 silent on fall", pc[1], 0);

      // R7 move ch1 from a low pin to a high pin: no pulse
      gpio_in[11] = 1'b1;
      idle(8);
      wr(5'h04, 32'hFF0A_0BFF);
      watch(12);
      check("R7 no pulse on reselect ch1", pc[1], 0);
      check("R7 untouched ch2 quiet", pc[2], 0);
      // after the flush the channel still catches a real edge
      gpio_in[11] = 1'b0;
      idle(6);
      gpio_in[11] = 1'b1;
      watch(10);
      check("R7 detection resumes ch1", pc[1], 1);

      // R8 glitch filter, k=1 => 4 stable clocks
      gpio_in = '0;
      wr(5'h00, 32'h0);
      wr(5'h04, 32'hFFFF_FF07);
      wr(5'h0C, 32'h0000_0001);
      idle(10);
      gpio_in[7] = 1'b1;
      idle(2);
      gpio_in[7] = 1'b0;
      watch(15);
      check("R8 short glitch dropped", pc[0], 0);
      gpio_in[7] = 1'b1;
      idle(5);
      check("R8 not yet passed", 32'(irq_out[0]), 32'h0);
      idle(1);
      check("R8 passed after 4k clocks", 32'(irq_out[0]), 32'h1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule